// File: doc/BRIEF.md
# Five-Stage In-Order Pipelined Processor Core

This block is a small word-addressed load-store processor split into five stages: instruction fetch, decode with register read, execute, memory access and writeback. Edge-triggered pipeline registers separate the stages. It runs six operations on an eight-entry, 32-bit register file: add, nand, load word, store word, branch-if-equal and halt. Any other opcode is a no-operation. The instruction memory and the data memory are word arrays inside the block. Both are written through preload ports while the core is held in reset, and both are read combinationally at the address their stage presents.

There is no forwarding, no interlock, no branch prediction and no squashing. Software must space a dependent instruction at least three slots after its producer. The three instructions after a branch always run. A small run controller has two states. In RUN the pipeline advances every cycle. The transition RUN to HALTED is taken when a halt instruction sits in writeback. In that cycle the pipeline, the program counter and every write are already frozen. HALTED raises the done flag and holds everything until the next reset. The program counter, the whole register file and the done flag are visible at the ports.

Top module: `pipe5_core`

## Requirements
- R1: An active-low asynchronous reset sets the program counter to 0, clears all eight registers, lowers done, and loads every pipeline register with a no-operation whose fields are zero. No register changes in cycles 0 to 4 after reset release.
- R2: Without a taken branch or a halt, the program counter increases by one every cycle. The instruction at address k is fetched in cycle k, and its register result is visible in cycle k+5.
- R3: Instruction fields are laid out as follows. The opcode is bits 27:25, with add=0, nand=1, load=2, store=3, branch=4, halt=6, noop=7, and 5 behaving as noop. Source A is bits 24:22 and source B is bits 18:16. The register-type destination is bits 2:0. The offset is bits 15:0, two's complement, sign-extended to 32 bits.
- R4: Add writes A+B and nand writes the inverse of A AND B, in both cases to the register named by bits 2:0.
- R5: Load reads the data word at A+offset and writes it to the register named by bits 18:16.
- R6: Store writes the contents of register B to the data word at A+offset during its memory stage. It writes no register.
- R7: When writeback writes a register in the same cycle that decode reads it, decode receives the new value.
- R8: A branch at address k whose two sources are equal redirects the program counter to k+1+offset, visible in cycle k+4. The three instructions after the branch still execute, and the instruction at k+4 does not.
- R9: A branch whose sources differ does not redirect fetch.
- R10: While a halt is in writeback, the program counter holds and no later instruction writes a register or memory. Done rises in the next cycle and stays high, and the program counter and registers stay unchanged until reset.
- R11: During reset, a high load enable writes the word on the load data port into instruction or data memory at the load address on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_ld_en | input | 1 | Instruction memory preload write enable |
| imem_ld_addr | input | IAW | Instruction memory preload word address |
| imem_ld_data | input | 32 | Instruction memory preload word |
| dmem_ld_en | input | 1 | Data memory preload write enable |
| dmem_ld_addr | input | DAW | Data memory preload word address |
| dmem_ld_data | input | 32 | Data memory preload word |
| pc_o | output | 32 | Current fetch address |
| regs_o | output | 256 | Register file, register n at bits 32n+31:32n |
| done_o | output | 1 | High once a halt has retired |

## Verification
Two pairs of functions can fall in the same cycle. In the first, writeback updates a register while decode reads that same register. This is provoked by placing a consumer exactly three slots after its producer, and it is judged by the consumer's own result appearing in the predicted cycle. In the second, a store commits in its memory stage while a later load reads the same word. A load placed just past that window must return the stored word, and a store whose low offset bits name a register must leave that register untouched. Every expected value is tied to an exact cycle after reset release, so a result that comes one cycle early or late is reported as well as a wrong value.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;

    localparam int WORD_W  = 32;
    localparam int REG_AW  = 3;
    localparam int OFF_W   = 16;
    localparam int OPC_LSB = 25;
    localparam int SRCA_LSB = 22;
    localparam int SRCB_LSB = 16;
    localparam int DSTR_LSB = 0;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_NAND = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_RSVD = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } opcode_e;

    typedef enum logic {
        ST_RUN,
        ST_HALTED
    } run_state_e;

    localparam logic [WORD_W-1:0] NOOP_WORD = 32'h0E00_0000;

    typedef struct packed {
        logic [WORD_W-1:0] instr;
        logic [WORD_W-1:0] pc1;
    } fd_reg_t;

    typedef struct packed {
        opcode_e           op;
        logic [REG_AW-1:0] dst_r;
        logic [REG_AW-1:0] dst_b;
        logic [WORD_W-1:0] va;
        logic [WORD_W-1:0] vb;
        logic [WORD_W-1:0] off;
        logic [WORD_W-1:0] pc1;
    } dx_reg_t;

    typedef struct packed {
        opcode_e           op;
        logic [REG_AW-1:0] dst_r;
        logic [REG_AW-1:0] dst_b;
        logic [WORD_W-1:0] res;
        logic [WORD_W-1:0] vb;
        logic [WORD_W-1:0] tgt;
        logic              eq;
        logic [WORD_W-1:0] pc1;
    } xm_reg_t;

    typedef struct packed {
        opcode_e           op;
        logic [REG_AW-1:0] dst_r;
        logic [REG_AW-1:0] dst_b;
        logic [WORD_W-1:0] res;
        logic [WORD_W-1:0] mdat;
        logic [WORD_W-1:0] pc1;
    } mw_reg_t;

endpackage

// File: rtl/pipe5_wordmem.sv
module pipe5_wordmem #(
    parameter int W     = 32,
    parameter int DEPTH = 64,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
    parameter int W    = 32,
    parameter int AW   = 3,
    localparam int NREG = 1 << AW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   rsel_a,
    input  logic [AW-1:0]   rsel_b,
    output logic [W-1:0]    rval_a,
    output logic [W-1:0]    rval_b,
    input  logic            wen,
    input  logic [AW-1:0]   wsel,
    input  logic [W-1:0]    wval,
    output logic [NREG*W-1:0] flat_o
);

    logic [W-1:0] bank [NREG];

    generate
        for (genvar g = 0; g < NREG; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    bank[g] <= '0;
                end else if (wen && (wsel == AW'(g))) begin
                    bank[g] <= wval;
                end
            end
            assign flat_o[g*W +: W] = bank[g];
        end
    endgenerate

    // same-cycle write then read returns the incoming value
    assign rval_a = (wen && (wsel == rsel_a)) ? wval : bank[rsel_a];
    assign rval_b = (wen && (wsel == rsel_b)) ? wval : bank[rsel_b];

endmodule

// File: rtl/pipe5_alu.sv
module pipe5_alu
    import pipe5_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  opcode_e      op,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] off,
    output logic [W-1:0] res,
    output logic         eq
);

    always_comb begin
        eq = (opa == opb);
        unique case (op)
            OP_ADD:       res = opa + opb;
            OP_NAND:      res = ~(opa & opb);
            OP_LW, OP_SW: res = opa + off;
            default:      res = '0;
        endcase
    end

endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
    import pipe5_pkg::*;
#(
    parameter int IMEM_DEPTH = 64,
    parameter int DMEM_DEPTH = 64,
    localparam int IAW  = $clog2(IMEM_DEPTH),
    localparam int DAW  = $clog2(DMEM_DEPTH),
    localparam int NREG = 1 << REG_AW
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   imem_ld_en,
    input  logic [IAW-1:0]         imem_ld_addr,
    input  logic [WORD_W-1:0]      imem_ld_data,
    input  logic                   dmem_ld_en,
    input  logic [DAW-1:0]         dmem_ld_addr,
    input  logic [WORD_W-1:0]      dmem_ld_data,
    output logic [WORD_W-1:0]      pc_o,
    output logic [NREG*WORD_W-1:0] regs_o,
    output logic                   done_o
);

    localparam int EXT_W = WORD_W - OFF_W;

    // ---------------- run controller ----------------
    run_state_e state_q, state_d;
    logic       stop;
    logic       halt_in_wb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        stop    = 1'b0;
        done_o  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                stop = halt_in_wb;
                if (halt_in_wb) begin
                    state_d = ST_HALTED;
                end
            end
            ST_HALTED: begin
                stop   = 1'b1;
                done_o = 1'b1;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    // ---------------- pipeline registers ----------------
    fd_reg_t fd_q, fd_d;
    dx_reg_t dx_q, dx_d;
    xm_reg_t xm_q, xm_d;
    mw_reg_t mw_q, mw_d;

    logic [WORD_W-1:0] pc_q, pc_d;
    logic              br_taken;

    assign halt_in_wb = (mw_q.op == OP_HALT);
    assign br_taken   = (xm_q.op == OP_BEQ) && xm_q.eq;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pc_q <= '0;
            fd_q <= '{instr: NOOP_WORD, pc1: '0};
            dx_q <= '{op: OP_NOOP, default: '0};
            xm_q <= '{op: OP_NOOP, default: '0};
            mw_q <= '{op: OP_NOOP, default: '0};
        end else if (!stop) begin
            pc_q <= pc_d;
            fd_q <= fd_d;
            dx_q <= dx_d;
            xm_q <= xm_d;
            mw_q <= mw_d;
        end
    end

    assign pc_o = pc_q;

    // ---------------- fetch ----------------
    logic [WORD_W-1:0] fetch_word;

    pipe5_wordmem #(.W(WORD_W), .DEPTH(IMEM_DEPTH)) imem_i (
        .clk   (clk),
        .we    (imem_ld_en),
        .waddr (imem_ld_addr),
        .wdata (imem_ld_data),
        .raddr (pc_q[IAW-1:0]),
        .rdata (fetch_word)
    );

    always_comb begin
        pc_d = br_taken ? xm_q.tgt : (pc_q + 1'b1);
        fd_d = '{instr: fetch_word, pc1: pc_q + 1'b1};
    end

    // ---------------- decode ----------------
    opcode_e           dec_op;
    logic [REG_AW-1:0] sel_a, sel_b;
    logic [WORD_W-1:0] rd_a, rd_b;
    logic              wb_we;
    logic [REG_AW-1:0] wb_sel;
    logic [WORD_W-1:0] wb_val;

    assign sel_a = fd_q.instr[SRCA_LSB +: REG_AW];
    assign sel_b = fd_q.instr[SRCB_LSB +: REG_AW];

    pipe5_regfile #(.W(WORD_W), .AW(REG_AW)) rf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .rsel_a (sel_a),
        .rsel_b (sel_b),
        .rval_a (rd_a),
        .rval_b (rd_b),
        .wen    (wb_we),
        .wsel   (wb_sel),
        .wval   (wb_val),
        .flat_o (regs_o)
    );

    always_comb begin
        dec_op = opcode_e'(fd_q.instr[OPC_LSB +: 3]);
        if (dec_op == OP_RSVD) begin
            dec_op = OP_NOOP;
        end
        dx_d.op    = dec_op;
        dx_d.dst_r = fd_q.instr[DSTR_LSB +: REG_AW];
        dx_d.dst_b = sel_b;
        dx_d.va    = rd_a;
        dx_d.vb    = rd_b;
        dx_d.off   = {{EXT_W{fd_q.instr[OFF_W-1]}}, fd_q.instr[OFF_W-1:0]};
        dx_d.pc1   = fd_q.pc1;
    end

    // ---------------- execute ----------------
    logic [WORD_W-1:0] alu_res;
    logic              alu_eq;

    pipe5_alu #(.W(WORD_W)) alu_i (
        .op  (dx_q.op),
        .opa (dx_q.va),
        .opb (dx_q.vb),
        .off (dx_q.off),
        .res (alu_res),
        .eq  (alu_eq)
    );

    always_comb begin
        xm_d.op    = dx_q.op;
        xm_d.dst_r = dx_q.dst_r;
        xm_d.dst_b = dx_q.dst_b;
        xm_d.res   = alu_res;
        xm_d.vb    = dx_q.vb;
        xm_d.tgt   = dx_q.pc1 + dx_q.off;
        xm_d.eq    = alu_eq;
        xm_d.pc1   = dx_q.pc1;
    end

    // ---------------- memory ----------------
    logic              core_st;
    logic              dm_we;
    logic [DAW-1:0]    dm_waddr;
    logic [WORD_W-1:0] dm_wdata;
    logic [WORD_W-1:0] dm_rdata;

    assign core_st  = !stop && (xm_q.op == OP_SW);
    assign dm_we    = dmem_ld_en || core_st;
    assign dm_waddr = dmem_ld_en ? dmem_ld_addr : xm_q.res[DAW-1:0];
    assign dm_wdata = dmem_ld_en ? dmem_ld_data : xm_q.vb;

    pipe5_wordmem #(.W(WORD_W), .DEPTH(DMEM_DEPTH)) dmem_i (
        .clk   (clk),
        .we    (dm_we),
        .waddr (dm_waddr),
        .wdata (dm_wdata),
        .raddr (xm_q.res[DAW-1:0]),
        .rdata (dm_rdata)
    );

    always_comb begin
        mw_d.op    = xm_q.op;
        mw_d.dst_r = xm_q.dst_r;
        mw_d.dst_b = xm_q.dst_b;
        mw_d.res   = xm_q.res;
        mw_d.mdat  = dm_rdata;
        mw_d.pc1   = xm_q.pc1;
    end

    // ---------------- writeback ----------------
    always_comb begin
        wb_sel = (mw_q.op == OP_LW) ? mw_q.dst_b : mw_q.dst_r;
        wb_val = (mw_q.op == OP_LW) ? mw_q.mdat  : mw_q.res;
        wb_we  = !stop && ((mw_q.op == OP_ADD) || (mw_q.op == OP_NAND) ||
                           (mw_q.op == OP_LW));
    end

endmodule

// File: rtl/pipe5_core_chk.sv
module pipe5_core_chk
    import pipe5_pkg::*;
#(
    parameter int W    = WORD_W,
    parameter int NREG = 1 << REG_AW
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      pc,
    input logic              done,
    input logic              stop,
    input logic              br_taken,
    input logic [W-1:0]      br_tgt,
    input logic [NREG*W-1:0] regs
);

    assert_reset_pc_R1: assert property (@(posedge clk)
        !rst_n |=> (pc == '0) && !done);

    assert_pc_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && !br_taken) |=> pc == $past(pc) + 1'b1);

    assert_branch_redirect_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop && br_taken) |=> pc == $past(br_tgt));

    assert_halt_pc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> $stable(pc));

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    assert_halt_regs_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> $stable(regs));

endmodule

bind pipe5_core pipe5_core_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc       (pc_o),
    .done     (done_o),
    .stop     (stop),
    .br_taken (br_taken),
    .br_tgt   (xm_q.tgt),
    .regs     (regs_o)
);

// File: tb/pipe5_core_tb_top.sv
module pipe5_core_tb_top;
    import pipe5_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 64;
    localparam int WD_CYCLES  = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          imem_ld_en = 1'b0;
    logic [5:0]    imem_ld_addr = '0;
    logic [31:0]   imem_ld_data = '0;
    logic          dmem_ld_en = 1'b0;
    logic [5:0]    dmem_ld_addr = '0;
    logic [31:0]   dmem_ld_data = '0;
    logic [31:0]   pc_o;
    logic [255:0]  regs_o;
    logic          done_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    pipe5_core dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .imem_ld_en   (imem_ld_en),
        .imem_ld_addr (imem_ld_addr),
        .imem_ld_data (imem_ld_data),
        .dmem_ld_en   (dmem_ld_en),
        .dmem_ld_addr (dmem_ld_addr),
        .dmem_ld_data (dmem_ld_data),
        .pc_o         (pc_o),
        .regs_o       (regs_o),
        .done_o       (done_o)
    );

    typedef struct {
        int          cyc;
        int          kind;   // 0 register, 1 pc, 2 done
        int          idx;
        logic [31:0] val;
        string       tag;
    } sb_item_t;

    sb_item_t    sb_q[$];
    logic [31:0] prog [DEPTH];
    logic [31:0] dimg [DEPTH];
    int          checks = 0;
    int          failures = 0;

    function automatic logic [31:0] enc(opcode_e op, int ra, int rb, int low);
        logic [31:0] l = low;
        logic [31:0] a = ra;
        logic [31:0] b = rb;
        return {4'b0, op, a[2:0], 3'b0, b[2:0], l[15:0]};
    endfunction

    task automatic push(int cyc, int kind, int idx, logic [31:0] val, string tag);
        sb_item_t it;
        it.cyc = cyc; it.kind = kind; it.idx = idx; it.val = val; it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic clear_images();
        for (int i = 0; i < DEPTH; i++) begin
            prog[i] = NOOP_WORD;
            dimg[i] = '0;
        end
    endtask

    // driver: hold reset, preload both memories, release
    task automatic load_and_release();
        @(negedge clk);
        rst_n = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            @(negedge clk);
            imem_ld_en = 1'b1; imem_ld_addr = 6'(i); imem_ld_data = prog[i];
            dmem_ld_en = 1'b1; dmem_ld_addr = 6'(i); dmem_ld_data = dimg[i];
        end
        @(negedge clk);
        imem_ld_en = 1'b0;
        dmem_ld_en = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] observe(int kind, int idx);
        case (kind)
            0:       return regs_o[idx*32 +: 32];
            1:       return pc_o;
            default: return {31'b0, done_o};
        endcase
    endfunction

    // monitor: cycle 0 is the cycle in which reset is released
    task automatic monitor(int max_cyc);
        int cur = 0;
        while (sb_q.size() > 0) begin
            while (sb_q.size() > 0 && sb_q[0].cyc <= cur) begin
                sb_item_t it = sb_q.pop_front();
                logic [31:0] act = observe(it.kind, it.idx);
                checks++;
                if (act !== it.val) begin
                    failures++;
                    $display("FAIL %s cycle=%0d actual=%h expected=%h",
                             it.tag, cur, act, it.val);
                end
            end
            if (sb_q.size() == 0) break;
            @(posedge clk);
            @(negedge clk);
            cur++;
            if (cur > max_cyc) begin
                failures++;
                $display("FAIL R2 monitor timeout actual=%0d expected=%0d", cur, sb_q[0].cyc);
                sb_q.delete();
            end
        end
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=%0d expected=<%0d", WD_CYCLES, WD_CYCLES);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // ---------- program A: arithmetic, loads, stores, bypass, halt ----------
        clear_images();
        dimg[0]  = 32'd5;
        dimg[1]  = 32'd12;
        dimg[2]  = 32'hFFFF_FFFD;
        dimg[10] = 32'd7;
        dimg[11] = 32'h0000_0055;
        prog[0]  = enc(OP_LW,   0, 1, 0);
        prog[1]  = enc(OP_LW,   0, 2, 1);
        prog[2]  = enc(OP_LW,   0, 3, 2);
        prog[5]  = enc(OP_ADD,  1, 2, 4);
        prog[6]  = enc(OP_NAND, 1, 2, 5);
        prog[7]  = enc(OP_LW,   3, 6, 13);
        prog[8]  = enc(OP_ADD,  4, 4, 7);
        prog[9]  = enc(OP_LW,   2, 0, -1);
        prog[11] = enc(OP_SW,   3, 7, 23);
        prog[12] = enc(OP_LW,   2, 5, 8);
        prog[13] = enc(OP_HALT, 0, 0, 0);
        prog[14] = enc(OP_ADD,  1, 2, 1);

        for (int r = 0; r < 8; r++) push(0, 0, r, 32'd0, "R1 register cleared by reset");
        push(0, 1, 0, 32'd0, "R1 pc after reset");
        push(0, 2, 0, 32'd0, "R1 done low after reset");
        push(3, 1, 0, 32'd3, "R2 pc steps by one");
        push(4, 0, 1, 32'd0, "R2 R1 no write before cycle 5");
        push(5, 0, 1, 32'd5, "R5 R11 load from preloaded word");
        push(6, 0, 2, 32'd12, "R5 load to bits 18:16 register");
        push(7, 0, 3, 32'hFFFF_FFFD, "R5 load negative word");
        push(9, 0, 4, 32'd0, "R2 add not yet visible");
        push(10, 0, 4, 32'd17, "R4 add result");
        push(11, 0, 5, 32'hFFFF_FFFB, "R4 nand result");
        push(12, 0, 6, 32'd7, "R5 load with negative base");
        push(13, 0, 7, 32'd34, "R7 same-cycle write and read");
        push(14, 0, 0, 32'h0000_0055, "R3 negative offset sign-extended");
        push(16, 0, 7, 32'd34, "R6 store writes no register");
        push(17, 0, 5, 32'd34, "R6 stored word read back");
        push(17, 1, 0, 32'd17, "R10 pc frozen with halt in writeback");
        push(17, 2, 0, 32'd0, "R10 done not yet high");
        push(18, 2, 0, 32'd1, "R10 done rises");
        push(25, 1, 0, 32'd17, "R10 pc held after halt");
        push(25, 2, 0, 32'd1, "R10 done stays high");
        push(25, 0, 1, 32'd5, "R10 instruction after halt has no effect");
        push(25, 0, 0, 32'h0000_0055, "R5 load writes no bits 2:0 register");

        load_and_release();
        monitor(60);

        // ---------- program B: taken and untaken branches ----------
        clear_images();
        dimg[0] = 32'd9;
        dimg[1] = 32'd9;
        dimg[2] = 32'd4;
        prog[0]  = enc(OP_LW,   0, 1, 0);
        prog[1]  = enc(OP_LW,   0, 2, 1);
        prog[2]  = enc(OP_LW,   0, 3, 2);
        prog[5]  = enc(OP_BEQ,  1, 2, 4);
        prog[6]  = enc(OP_ADD,  3, 3, 4);
        prog[9]  = enc(OP_ADD,  1, 1, 5);
        prog[10] = enc(OP_ADD,  3, 1, 6);
        prog[11] = enc(OP_BEQ,  1, 3, -5);
        prog[12] = enc(OP_NAND, 3, 3, 7);
        prog[13] = enc(OP_HALT, 0, 0, 0);

        push(0, 0, 1, 32'd0, "R1 registers cleared by second reset");
        push(0, 0, 5, 32'd0, "R1 register 5 cleared by second reset");
        push(0, 1, 0, 32'd0, "R1 pc cleared by second reset");
        push(0, 2, 0, 32'd0, "R1 done cleared by second reset");
        push(5, 0, 1, 32'd9, "R5 load");
        push(7, 0, 3, 32'd4, "R5 load");
        push(8, 1, 0, 32'd8, "R2 pc before redirect");
        push(9, 1, 0, 32'd10, "R8 taken branch target");
        push(11, 0, 4, 32'd8, "R8 slot after branch executes");
        push(12, 1, 0, 32'd13, "R2 pc steps after redirect");
        push(14, 1, 0, 32'd15, "R9 untaken branch falls through");
        push(14, 0, 6, 32'd13, "R8 instruction at target executes");
        push(16, 0, 7, 32'hFFFF_FFFB, "R9 instruction after untaken branch");
        push(16, 1, 0, 32'd17, "R10 pc at halt");
        push(17, 2, 0, 32'd1, "R10 done rises");
        push(20, 0, 5, 32'd0, "R8 skipped instruction never ran");
        push(20, 1, 0, 32'd17, "R10 pc held");

        load_and_release();
        monitor(60);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule